// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Decoder

This block sits on the qualified write path of a byte-wide non-volatile memory and watches every write cycle (address plus data). It recognises fixed multi-write command sequences. One temporarily unlocks writing and, the first time it is used, switches software write protection on for good. One enters a product-identification read mode and one leaves it. A six-write sequence turns protection off again. Any write that does not advance a command sequence is a sector-load byte. While protection is on, a load is accepted only if a fresh unlock sequence came before it. A load without that unlock changes nothing and starts a lockout that blocks all reads and writes for a fixed number of cycles.

A sector load is a burst of data writes. The burst stays open while the gap between writes stays below a parameterised byte-load window. When the window runs out, the burst closes and the unlock permission is used up. Inside a burst, every write counts as data, even one that looks like a command step. The block also drives the read data path. In identification mode it returns the manufacturer code at address 0 and a parameterised device code at address 1. During a lockout every read returns FF.

Top module: `wp_seq_decoder`

## Requirements
- R1: After reset, protect_enabled, id_mode and lockout are 0 and write_permitted is 1.
- R2: While protection is off, every data write (a write that does not advance any command sequence) asserts byte_accept in its strobe cycle and never starts a lockout.
- R3: The three writes AA to 5555, 55 to 2AAA, A0 to 5555 (hex) set protect_enabled to 1 and grant write permission: write_permitted is 1 and the data writes that follow are accepted.
- R4: A load burst ends when BLC_CYCLES clock cycles pass with no write. This uses up the permission: write_permitted drops to 0 and protect_enabled stays 1.
- R5: A data write made while protection is on and no permission is held is not accepted. It raises lockout for exactly LOCK_CYCLES cycles. During that time, writes are ignored: no byte_accept, and command sequences have no effect.
- R6: While lockout is 1, rd_data reads FF whatever the address and the mode.
- R7: The writes AA to 5555, 55 to 2AAA, 90 to 5555 set id_mode. In id_mode, a read of address 0 returns 1F and a read of address 1 returns DEV_CODE. Every other address returns rd_array_data.
- R8: The writes AA to 5555, 55 to 2AAA, F0 to 5555 clear id_mode, and reads then return rd_array_data at every address.
- R9: The six writes set by DIS_ADDR/DIS_DATA clear protect_enabled. By default these are AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, 20 to 5555. After them, data writes are accepted without permission.
- R10: A write that breaks a partly matched sequence sends the matcher back to idle. That same write is then tried as the first step of a new sequence. So AA/5555, AA/5555, 55/2AAA, A0/5555 still unlocks, while AA/5555, 55/2AAA, 77/5555 changes no state.
- R11: Command addresses are compared on the low 15 bits only. Setting bit 16 of every address in the unlock sequence still unlocks.
- R12: Inside an open load burst every write is a data byte. A command sequence written there is accepted as data and does not change id_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe of a qualified write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_array_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data after identification and lockout override |
| byte_accept | output | 1 | This strobe is a sector byte to be stored |
| protect_enabled | output | 1 | Software write protection is on |
| write_permitted | output | 1 | A data write now would be accepted |
| id_mode | output | 1 | Identification read mode is active |
| lockout | output | 1 | Lockout timer is running |

## Verification
On every cycle, the assertions check these invariants: permission is never held without protection; protection stays on until the disable sequence completes; the mode state is frozen while the lockout runs; a refused load always starts the lockout; an accepted byte always opens a burst; and the matcher step counters stay in range and return to idle after a completion. Only the bench scenarios can show the command encodings themselves. These are the restart of a broken sequence on the same write, the 15-bit address compare, the exact lockout length, the permission being used up at the end of a burst, and the identification and lockout read values across the address sweep.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  localparam int CMP_W = 15;
  localparam int DATA_W = 8;
  localparam int NUM_SHORT = 3;
  localparam int SHORT_LEN = 3;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CMP_W-1:0] caddr_t;

  typedef enum logic [1:0] {
    CMD_UNLOCK   = 2'd0,
    CMD_ID_ENTER = 2'd1,
    CMD_ID_EXIT  = 2'd2
  } short_cmd_e;

  localparam byte_t MFR_CODE = 8'h1F;
  localparam byte_t LOCK_READ = 8'hFF;
  localparam caddr_t CMD_A_HI = 15'h5555;
  localparam caddr_t CMD_A_LO = 15'h2AAA;
  localparam byte_t CMD_D_1 = 8'hAA;
  localparam byte_t CMD_D_2 = 8'h55;

  function automatic byte_t short_final(input int idx);
    case (idx)
      0:       short_final = 8'hA0;
      1:       short_final = 8'h90;
      default: short_final = 8'hF0;
    endcase
  endfunction
endpackage

// File: rtl/wpd_seq_matcher.sv
module wpd_seq_matcher
  import wpd_pkg::*;
#(
  parameter int N = 3,
  parameter logic [N*CMP_W-1:0] STEP_ADDR = '0,
  parameter logic [N*DATA_W-1:0] STEP_DATA = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  caddr_t addr,
  input  byte_t  data,
  output logic   adv,
  output logic   done
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  caddr_t exp_addr;
  byte_t  exp_data;
  logic   hit_cur, hit_first;

  always_comb begin
    exp_addr  = STEP_ADDR[int'(cnt_q)*CMP_W +: CMP_W];
    exp_data  = STEP_DATA[int'(cnt_q)*DATA_W +: DATA_W];
    hit_cur   = (addr == exp_addr) && (data == exp_data);
    hit_first = (addr == STEP_ADDR[CMP_W-1:0]) && (data == STEP_DATA[DATA_W-1:0]);
  end

  always_comb begin
    cnt_d = cnt_q;
    done  = 1'b0;
    adv   = 1'b0;
    if (en) begin
      adv = hit_cur || hit_first;
      if (hit_cur) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          done  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (hit_first) begin
        cnt_d = CNT_W'(1);
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("step counter out of range"); // R10

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0)) else $error("matcher not idle after completion"); // R10
endmodule

// File: rtl/wpd_interval_timer.sv
module wpd_interval_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic expire
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? LEN_V : (cnt_q - 1'b1);
    busy   = (cnt_q != '0);
    expire = (cnt_q == CW'(1)) && !load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_V) else $error("timer above its length"); // R5

  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == LEN_V)) else $error("timer did not reload"); // R4
endmodule

// File: rtl/wp_seq_decoder.sv
module wp_seq_decoder
  import wpd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LOCK_CYCLES = 1000000,
  parameter int BLC_CYCLES = 15000,
  parameter logic [7:0] DEV_CODE = 8'hD5,
  parameter logic [6*CMP_W-1:0] DIS_ADDR = {15'h5555, 15'h2AAA, 15'h5555,
                                            15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [6*DATA_W-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                             8'h80, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_array_data,
  output logic [7:0]        rd_data,
  output logic              byte_accept,
  output logic              protect_enabled,
  output logic              write_permitted,
  output logic              id_mode,
  output logic              lockout
);
  logic   protect_q, protect_d;
  logic   permit_q, permit_d;
  logic   id_q, id_d;
  logic   lock_busy, lock_expire, lock_start;
  logic   burst_busy, burst_expire;
  logic   live_wr, mat_en, any_adv, data_wr, allowed;
  caddr_t cmp_addr;
  logic [NUM_SHORT-1:0] short_adv, short_done;
  logic   dis_adv, dis_done;

  assign cmp_addr = wr_addr[CMP_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SHORT; gi++) begin : g_short
      localparam byte_t FINAL = short_final(gi);
      wpd_seq_matcher #(
        .N(SHORT_LEN),
        .STEP_ADDR({CMD_A_HI, CMD_A_LO, CMD_A_HI}),
        .STEP_DATA({FINAL, CMD_D_2, CMD_D_1})
      ) u_match (
        .clk(clk), .rst_n(rst_n), .en(mat_en), .addr(cmp_addr), .data(wr_data),
        .adv(short_adv[gi]), .done(short_done[gi])
      );
    end
  endgenerate

  wpd_seq_matcher #(
    .N(6), .STEP_ADDR(DIS_ADDR), .STEP_DATA(DIS_DATA)
  ) u_disable (
    .clk(clk), .rst_n(rst_n), .en(mat_en), .addr(cmp_addr), .data(wr_data),
    .adv(dis_adv), .done(dis_done)
  );

  wpd_interval_timer #(.LEN(LOCK_CYCLES)) u_lock_tmr (
    .clk(clk), .rst_n(rst_n), .load(lock_start), .busy(lock_busy), .expire(lock_expire)
  );

  wpd_interval_timer #(.LEN(BLC_CYCLES)) u_burst_tmr (
    .clk(clk), .rst_n(rst_n), .load(byte_accept), .busy(burst_busy), .expire(burst_expire)
  );

  always_comb begin
    live_wr     = wr_stb && !lock_busy;
    mat_en      = live_wr && !burst_busy;
    any_adv     = (|short_adv) || dis_adv;
    data_wr     = live_wr && (burst_busy || !any_adv);
    allowed     = !protect_q || permit_q;
    byte_accept = data_wr && allowed;
    lock_start  = data_wr && !allowed;
  end

  always_comb begin
    protect_d = protect_q;
    permit_d  = permit_q;
    id_d      = id_q;
    if (dis_done) begin
      protect_d = 1'b0;
      permit_d  = 1'b0;
    end else if (short_done[CMD_UNLOCK]) begin
      protect_d = 1'b1;
      permit_d  = 1'b1;
    end else if (burst_expire) begin
      permit_d  = 1'b0;
    end
    if (short_done[CMD_ID_ENTER]) id_d = 1'b1;
    else if (short_done[CMD_ID_EXIT]) id_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect_q <= 1'b0;
      permit_q  <= 1'b0;
      id_q      <= 1'b0;
    end else begin
      protect_q <= protect_d;
      permit_q  <= permit_d;
      id_q      <= id_d;
    end
  end

  always_comb begin
    if (lock_busy)
      rd_data = LOCK_READ;
    else if (id_q && (rd_addr == ADDR_W'(0)))
      rd_data = MFR_CODE;
    else if (id_q && (rd_addr == ADDR_W'(1)))
      rd_data = DEV_CODE;
    else
      rd_data = rd_array_data;
  end

  assign protect_enabled = protect_q;
  assign write_permitted = allowed && !lock_busy;
  assign id_mode         = id_q;
  assign lockout         = lock_busy;

  AST_PERMIT_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    permit_q |-> protect_q) else $error("permission without protection"); // R3

  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_q && !dis_done) |=> protect_q) else $error("protection dropped"); // R3

  AST_LOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> lockout) else $error("refused load without lockout"); // R5

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |=> ($stable(protect_q) && $stable(permit_q) && $stable(id_q)))
    else $error("state changed during lockout"); // R5

  AST_ACCEPT_OPENS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |=> burst_busy) else $error("accepted byte without burst"); // R12

  AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (rd_data == LOCK_READ)) else $error("read not blocked"); // R6
endmodule

// File: tb/wp_seq_decoder_tb.sv
module wp_seq_decoder_tb;
  localparam int ADDR_W = 17;
  localparam int LOCK = 40;
  localparam int BLC = 8;
  localparam logic [7:0] DEV = 8'hD5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0] rd_array_data;
  logic [7:0] rd_data;
  logic byte_accept, protect_enabled, write_permitted, id_mode, lockout;

  int checks = 0;
  int failures = 0;
  logic acc;

  always #5 clk = ~clk;
  assign rd_array_data = rd_addr[7:0] ^ 8'h5A;

  wp_seq_decoder #(.ADDR_W(ADDR_W), .LOCK_CYCLES(LOCK), .BLC_CYCLES(BLC), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_array_data(rd_array_data), .rd_data(rd_data),
    .byte_accept(byte_accept), .protect_enabled(protect_enabled),
    .write_permitted(write_permitted), .id_mode(id_mode), .lockout(lockout)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    #1 acc = byte_accept;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic seq3(input logic [ADDR_W-1:0] hi, input logic [7:0] last);
    wr(17'h05555 | hi, 8'hAA);
    wr(17'h02AAA | hi, 8'h55);
    wr(17'h05555 | hi, last);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(protect_enabled == 0, "R1 protect", protect_enabled, 0);
    check(id_mode == 0, "R1 id", id_mode, 0);
    check(lockout == 0, "R1 lockout", lockout, 0);
    check(write_permitted == 1, "R1 permitted", write_permitted, 1);

    // R2 unprotected data writes sweep
    for (int i = 0; i < 8; i++) begin
      wr(17'h100 + 17'(i), 8'(i * 37));
      check(acc == 1, "R2 accept", acc, 1);
    end
    check(lockout == 0, "R2 no lockout", lockout, 0);
    idle(BLC + 2);

    // R10 broken sequence changes nothing
    seq3(17'h0, 8'h77);
    check(protect_enabled == 0, "R10 broken", protect_enabled, 0);
    idle(BLC + 2);

    // R10 restart on breaking write, completes unlock (R3)
    wr(17'h05555, 8'hAA);
    seq3(17'h0, 8'hA0);
    check(protect_enabled == 1, "R10 restart protect", protect_enabled, 1);
    check(write_permitted == 1, "R3 permitted", write_permitted, 1);
    for (int i = 0; i < 4; i++) begin
      wr(17'h200 + 17'(i), 8'hC0 + 8'(i));
      check(acc == 1, "R3 accept", acc, 1);
    end
    // R12 command sequence inside burst is data
    wr(17'h05555, 8'hAA); check(acc == 1, "R12 accept1", acc, 1);
    wr(17'h02AAA, 8'h55); check(acc == 1, "R12 accept2", acc, 1);
    wr(17'h05555, 8'h90); check(acc == 1, "R12 accept3", acc, 1);
    check(id_mode == 0, "R12 id unchanged", id_mode, 0);
    idle(BLC + 2);
    // R4 permission consumed
    check(write_permitted == 0, "R4 permitted", write_permitted, 0);
    check(protect_enabled == 1, "R4 protect", protect_enabled, 1);

    // R5 refused load and lockout
    rd_addr = 17'h0;
    wr(17'h300, 8'h11);
    check(acc == 0, "R5 refused", acc, 0);
    check(lockout == 1, "R5 lockout", lockout, 1);
    check(rd_data == 8'hFF, "R6 locked read", rd_data, 8'hFF);
    wr(17'h05555, 8'hAA); check(acc == 0, "R5 ignored1", acc, 0);
    wr(17'h02AAA, 8'h55); check(acc == 0, "R5 ignored2", acc, 0);
    wr(17'h05555, 8'hA0); check(acc == 0, "R5 ignored3", acc, 0);
    n = 0;
    while (lockout && n < 1000) begin
      rd_addr = 17'(n + 3);
      #1 check(rd_data == 8'hFF, "R6 locked sweep", rd_data, 8'hFF);
      n++;
      @(negedge clk);
    end
    check(n == LOCK - 3, "R5 lockout length", n, LOCK - 3);
    check(write_permitted == 0, "R5 unlock ignored", write_permitted, 0);

    // R11 upper address bit ignored
    seq3(17'h10000, 8'hA0);
    check(write_permitted == 1, "R11 unlock", write_permitted, 1);
    wr(17'h400, 8'h22);
    check(acc == 1, "R11 accept", acc, 1);
    idle(BLC + 2);

    // R7 id mode and read sweep
    seq3(17'h0, 8'h90);
    check(id_mode == 1, "R7 id set", id_mode, 1);
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      rd_addr = 17'(a);
      e = (a == 0) ? 8'h1F : (a == 1) ? DEV : (8'(a) ^ 8'h5A);
      #1 check(rd_data == e, "R7 id read", rd_data, e);
    end
    rd_addr = 17'h10000;
    #1 check(rd_data == 8'h5A, "R7 high addr", rd_data, 8'h5A);
    @(negedge clk);

    // R8 exit id mode
    seq3(17'h0, 8'hF0);
    check(id_mode == 0, "R8 id clear", id_mode, 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 17'(a);
      #1 check(rd_data == (8'(a) ^ 8'h5A), "R8 array read", rd_data, 8'(a) ^ 8'h5A);
    end
    @(negedge clk);

    // R9 disable sequence
    seq3(17'h0, 8'h80);
    seq3(17'h0, 8'h20);
    check(protect_enabled == 0, "R9 protect off", protect_enabled, 0);
    check(write_permitted == 1, "R9 permitted", write_permitted, 1);
    wr(17'h500, 8'h33);
    check(acc == 1, "R9 accept", acc, 1);
    check(lockout == 0, "R9 no lockout", lockout, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule